// File: doc/BRIEF.md
# TLB Invalidate Operation Engine

This block carries out an invalidate-TLB request against a small fully associative translation array. Each array entry carries a valid flag, a global flag, an address-space identifier (ASID) and a virtual page number (VPN). A request supplies a 5-bit operation code, an ASID operand, a VPN operand and the current privilege state. The operation code selects the rule that decides which entries are dropped.

The array itself sits outside the engine. The engine steps an entry index over the array, one entry per cycle in ascending order. It reads the addressed entry's fields back on its inputs and raises an invalidate strobe for each entry that the rule selects. The array owner clears that entry's valid flag on the same clock edge. When the walk ends, the engine gives a one-cycle done pulse. Two other outcomes skip the walk and end with a one-cycle pulse of their own: an unknown operation code, and a request made from user privilege.

Top module: `tlb_inv_engine`

## Requirements
- R1: Operation codes 0 and 1 invalidate every valid entry.
- R2: Operation code 2 invalidates exactly the valid entries whose global flag is 1.
- R3: Operation code 3 invalidates exactly the valid entries whose global flag is 0.
- R4: Operation code 4 invalidates the valid non-global entries whose ASID equals the ASID operand. Global entries are kept.
- R5: Operation code 5 invalidates the valid non-global entries whose ASID equals the ASID operand and whose VPN equals the VPN operand.
- R6: Operation code 6 invalidates the valid entries whose VPN equals the VPN operand and that are either global or whose ASID equals the ASID operand.
- R7: An accepted request with an operation code of 7 to 31 from supervisor privilege gives a one-cycle pulse on `illegal_o` in the cycle after acceptance. It starts no walk and invalidates nothing.
- R8: An accepted request with `user_mode_i` = 1 gives a one-cycle pulse on `priv_exc_o` in the cycle after acceptance, whatever the operation code. It does not pulse `illegal_o`, starts no walk and invalidates nothing.
- R9: A legal request accepted at clock edge E raises `busy_o` from E on. `idx_o` then presents entry 0, 1, ..., N-1, one per cycle. At edge E+N, `busy_o` falls and `done_o` pulses for one cycle.
- R10: While `busy_o` is 1, a request on `req_i` has no effect. The walk in progress keeps its rule and its timing, and no flag pulse results.
- R11: `inv_o` is asserted only while `busy_o` is 1, and only for an entry whose valid flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when the engine is idle |
| op_i | input | 5 | Operation code |
| asid_i | input | ASID_W | ASID operand |
| vpn_i | input | VPN_W | VPN operand |
| user_mode_i | input | 1 | 1 when the requester runs at user privilege |
| idx_o | output | IDX_W | Index of the entry under examination |
| ent_valid_i | input | 1 | Valid flag of entry idx_o |
| ent_global_i | input | 1 | Global flag of entry idx_o |
| ent_asid_i | input | ASID_W | ASID of entry idx_o |
| ent_vpn_i | input | VPN_W | VPN of entry idx_o |
| inv_o | output | 1 | Clear the valid flag of entry idx_o at this clock edge |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| illegal_o | output | 1 | One-cycle pulse for an unknown operation code |
| priv_exc_o | output | 1 | One-cycle pulse for a request from user privilege |

## Verification
A wrongly latched rule or operand cannot be seen until the walk ends. At that point the set of surviving valid flags differs from the arithmetic expectation in at least one entry, N+1 cycles after the request. A broken index counter or end-of-walk compare shows within the first cycles of the walk: either `idx_o` leaves the ascending sequence, or `done_o` arrives early, late or not at all. A wrong accept or flag decision shows one cycle after the request, as a missing or extra pulse or as `busy_o` rising when it must not.

// File: rtl/tlb_inv_pkg.sv
package tlb_inv_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ALL0    = 5'd0,
    OP_ALL1    = 5'd1,
    OP_GLB     = 5'd2,
    OP_NGLB    = 5'd3,
    OP_ASID    = 5'd4,
    OP_ASID_PG = 5'd5,
    OP_PG_AORG = 5'd6
  } inv_op_e;

  // match rule: each set term narrows the selection
  typedef struct packed {
    logic need_g;
    logic need_ng;
    logic use_asid;
    logic use_vpn;
    logic g_or_asid;
  } inv_rule_t;

  localparam inv_rule_t RULE_NONE = '{default: 1'b0};
endpackage

// File: rtl/tlb_inv_decode.sv
module tlb_inv_decode
  import tlb_inv_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output inv_rule_t       rule_o,
  output logic            legal_o
);
  always_comb begin
    rule_o  = RULE_NONE;
    legal_o = 1'b1;
    unique case (op_i)
      OP_ALL0, OP_ALL1: ;
      OP_GLB:     rule_o.need_g = 1'b1;
      OP_NGLB:    rule_o.need_ng = 1'b1;
      OP_ASID: begin
        rule_o.need_ng  = 1'b1;
        rule_o.use_asid = 1'b1;
      end
      OP_ASID_PG: begin
        rule_o.need_ng  = 1'b1;
        rule_o.use_asid = 1'b1;
        rule_o.use_vpn  = 1'b1;
      end
      OP_PG_AORG: begin
        rule_o.use_vpn   = 1'b1;
        rule_o.g_or_asid = 1'b1;
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_inv_match.sv
module tlb_inv_match
  import tlb_inv_pkg::*;
#(
  parameter int unsigned ASID_W = 10,
  parameter int unsigned VPN_W  = 19
) (
  input  inv_rule_t         rule_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              ent_valid_i,
  input  logic              ent_global_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VPN_W-1:0]  ent_vpn_i,
  output logic              hit_o
);
  logic asid_eq, vpn_eq;
  logic ok_g, ok_ng, ok_asid, ok_vpn, ok_aorg;

  assign asid_eq = (ent_asid_i == asid_i);
  assign vpn_eq  = (ent_vpn_i == vpn_i);

  assign ok_g    = !rule_i.need_g    || ent_global_i;
  assign ok_ng   = !rule_i.need_ng   || !ent_global_i;
  assign ok_asid = !rule_i.use_asid  || asid_eq;
  assign ok_vpn  = !rule_i.use_vpn   || vpn_eq;
  assign ok_aorg = !rule_i.g_or_asid || ent_global_i || asid_eq;

  assign hit_o = ent_valid_i && ok_g && ok_ng && ok_asid && ok_vpn && ok_aorg;
endmodule

// File: rtl/tlb_inv_walker.sv
module tlb_inv_walker
  import tlb_inv_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned ASID_W    = 10,
  parameter int unsigned VPN_W     = 19,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              user_mode_i,
  input  logic              legal_i,
  input  inv_rule_t         rule_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  output inv_rule_t         rule_q_o,
  output logic [ASID_W-1:0] asid_q_o,
  output logic [VPN_W-1:0]  vpn_q_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              priv_exc_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

  logic accept, start, last;

  assign accept = req_i && !busy_o;
  assign start  = accept && !user_mode_i && legal_i;
  assign last   = busy_o && (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      idx_o      <= '0;
      done_o     <= 1'b0;
      illegal_o  <= 1'b0;
      priv_exc_o <= 1'b0;
      rule_q_o   <= RULE_NONE;
      asid_q_o   <= '0;
      vpn_q_o    <= '0;
    end else begin
      done_o     <= last;
      illegal_o  <= accept && !user_mode_i && !legal_i;
      priv_exc_o <= accept && user_mode_i;
      if (start) begin
        busy_o   <= 1'b1;
        idx_o    <= '0;
        rule_q_o <= rule_i;
        asid_q_o <= asid_i;
        vpn_q_o  <= vpn_i;
      end else if (last) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else if (busy_o) begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_inv_engine.sv
module tlb_inv_engine
  import tlb_inv_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned ASID_W    = 10,
  parameter int unsigned VPN_W     = 19,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              user_mode_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              ent_valid_i,
  input  logic              ent_global_i,
  input  logic [ASID_W-1:0] ent_asid_i,
  input  logic [VPN_W-1:0]  ent_vpn_i,
  output logic              inv_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              priv_exc_o
);
  inv_rule_t         dec_rule, rule_q;
  logic              dec_legal, hit;
  logic [ASID_W-1:0] asid_q;
  logic [VPN_W-1:0]  vpn_q;

  tlb_inv_decode u_decode (
    .op_i    (op_i),
    .rule_o  (dec_rule),
    .legal_o (dec_legal)
  );

  tlb_inv_walker #(
    .N_ENTRIES (N_ENTRIES),
    .ASID_W    (ASID_W),
    .VPN_W     (VPN_W)
  ) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .user_mode_i (user_mode_i),
    .legal_i     (dec_legal),
    .rule_i      (dec_rule),
    .asid_i      (asid_i),
    .vpn_i       (vpn_i),
    .rule_q_o    (rule_q),
    .asid_q_o    (asid_q),
    .vpn_q_o     (vpn_q),
    .idx_o       (idx_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .illegal_o   (illegal_o),
    .priv_exc_o  (priv_exc_o)
  );

  tlb_inv_match #(
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W)
  ) u_match (
    .rule_i       (rule_q),
    .asid_i       (asid_q),
    .vpn_i        (vpn_q),
    .ent_valid_i  (ent_valid_i),
    .ent_global_i (ent_global_i),
    .ent_asid_i   (ent_asid_i),
    .ent_vpn_i    (ent_vpn_i),
    .hit_o        (hit)
  );

  assign inv_o = busy_o && hit;
endmodule

// File: rtl/tlb_inv_checker.sv
module tlb_inv_checker #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned IDX_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic [4:0]       op_i,
  input logic             user_mode_i,
  input logic [IDX_W-1:0] idx_o,
  input logic             ent_valid_i,
  input logic             inv_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             illegal_o,
  input logic             priv_exc_o
);
  AST_DONE_ENDS_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o) && $past(idx_o) == IDX_W'(N_ENTRIES - 1)); // R9
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> idx_o == IDX_W'($past(idx_o) + 1'b1)); // R9
  AST_INV_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_o |-> busy_o && ent_valid_i); // R11
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(req_i && !busy_o && !user_mode_i && op_i > 5'd6) && !busy_o); // R7
  AST_PRIV_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_exc_o |-> $past(req_i && !busy_o && user_mode_i) && !busy_o && !illegal_o); // R8
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && req_i |=> !illegal_o && !priv_exc_o); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, illegal_o, priv_exc_o})); // R9
endmodule

bind tlb_inv_engine tlb_inv_checker #(
  .N_ENTRIES (N_ENTRIES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .op_i        (op_i),
  .user_mode_i (user_mode_i),
  .idx_o       (idx_o),
  .ent_valid_i (ent_valid_i),
  .inv_o       (inv_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .priv_exc_o  (priv_exc_o)
);

// File: tb/tlb_inv_engine_bench.sv
`timescale 1ns/1ps
module tlb_inv_engine_bench;
  localparam int N = 16;
  localparam int AW = 10;
  localparam int VW = 19;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, user = 1'b0;
  logic [4:0] op = '0;
  logic [AW-1:0] asid = '0;
  logic [VW-1:0] vpn = '0;
  logic [3:0] idx;
  logic inv, busy, done, illegal, priv;

  logic [N-1:0] m_v, m_g, load_v;
  logic [AW-1:0] m_asid [N];
  logic [VW-1:0] m_vpn [N];
  logic load_en = 1'b0;

  int total = 0, fails = 0;

  always #2 clk = ~clk;

  tlb_inv_engine u_tlb_inv_engine (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .asid_i(asid),
    .vpn_i(vpn), .user_mode_i(user), .idx_o(idx),
    .ent_valid_i(m_v[idx]), .ent_global_i(m_g[idx]),
    .ent_asid_i(m_asid[idx]), .ent_vpn_i(m_vpn[idx]),
    .inv_o(inv), .busy_o(busy), .done_o(done), .illegal_o(illegal), .priv_exc_o(priv)
  );

  // array model owned by the bench
  always @(posedge clk) begin
    if (load_en) m_v <= load_v;
    else if (inv) m_v[idx] <= 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pat_v(int p);
    for (int i = 0; i < N; i++) pat_v[i] = ((i * 5 + p) % 4) != 0;
  endfunction

  task automatic fill(int p);
    for (int i = 0; i < N; i++) begin
      m_g[i]    = ((i + p) % 3) == 0;
      m_asid[i] = AW'((i + p) % 4);
      m_vpn[i]  = VW'(((i % 3) << 8) + p);
    end
    @(negedge clk);
    load_v = pat_v(p); load_en = 1'b1;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  function automatic bit exp_hit(int o, int i, int p, int a, int pg);
    bit g, ae, pe;
    g  = ((i + p) % 3) == 0;
    ae = ((i + p) % 4) == a;
    pe = (((i % 3) << 8) + p) == pg;
    case (o)
      0, 1: return 1'b1;
      2: return g;
      3: return !g;
      4: return !g && ae;
      5: return !g && ae && pe;
      6: return pe && (g || ae);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int o, bit u);
    if (u) return "R8";
    case (o)
      0, 1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R7";
    endcase
  endfunction

  // issue one request; optionally inject a second request mid-walk
  task automatic run(int o, int p, int a, int pg, bit u, bit inject);
    logic [N-1:0] expv;
    bit idx_ok;
    fill(p);
    expv = pat_v(p);
    if (!u && o <= 6)
      for (int i = 0; i < N; i++) if (exp_hit(o, i, p, a, pg)) expv[i] = 1'b0;
    @(negedge clk);
    req = 1'b1; op = 5'(o); asid = AW'(a); vpn = VW'(pg); user = u;
    @(negedge clk);
    req = 1'b0; user = 1'b0;
    if (!u && o <= 6) begin
      chk(busy && !done, "R9 busy after accept", busy, 1);
      idx_ok = 1'b1;
      for (int k = 0; k < N; k++) begin
        if (idx != 4'(k)) idx_ok = 1'b0;
        if (inject && k == 5) begin
          req = 1'b1; op = 5'd0; user = 1'b0;
        end else begin
          req = 1'b0;
        end
        @(negedge clk);
      end
      req = 1'b0;
      chk(idx_ok, "R9 index order", idx_ok, 1);
      chk(done && !busy && !illegal && !priv, inject ? "R10 done timing" : "R9 done timing",
          {busy, done}, 2'b01);
      @(negedge clk);
      chk(!done && !busy, "R9 done one cycle", {busy, done}, 0);
    end else begin
      chk(!busy && !done && (priv == u) && (illegal == !u), tag_of(o, u),
          {busy, done, illegal, priv}, {2'b00, !u, u});
      @(negedge clk);
      chk(!illegal && !priv, {tag_of(o, u), " pulse one cycle"}, {illegal, priv}, 0);
    end
    chk(m_v == expv, inject ? "R10 survivors" : tag_of(o, u), m_v, expv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    load_v = '0;
    m_g = '0;
    for (int i = 0; i < N; i++) begin m_asid[i] = '0; m_vpn[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !priv && !inv && idx == 0, "R9 reset state",
        {busy, done, illegal, priv, inv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep all opcodes over four array patterns
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 32; o++)
        run(o, p, (p + 1) % 4, 256 + p, 1'b0, 1'b0);
    // page operands that hit other rows, and a page that hits nothing
    for (int o = 5; o <= 6; o++) begin
      run(o, 1, 2, 512 + 1, 1'b0, 1'b0);
      run(o, 2, 0, 2, 1'b0, 1'b0);
      run(o, 3, 3, 1023, 1'b0, 1'b0);
    end
    // R8: user privilege refused for legal and illegal codes
    for (int o = 0; o < 32; o += 3) run(o, o % 4, 1, 256, 1'b1, 1'b0);
    // R10: a request injected while a walk runs is ignored
    run(2, 0, 1, 256, 1'b0, 1'b1);
    run(5, 1, 2, 257, 1'b0, 1'b1);
    // R11 is also held by the survivor checks: invalid rows stay invalid
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule